// File: doc/BRIEF.md
# SPI Flash Command Controller

This block is an SPI master that runs one flash command at a time under control of a byte-wide register bus. Software writes an opcode and a pair of byte counts, then loads the outgoing data bytes into an eight-entry buffer through a data port. A start bit then makes the block drive chip select low and shift out the opcode. The outgoing bytes follow, and then the requested number of read bytes are clocked in. Every received data byte lands in the same buffer, placed after the transmitted ones.

Buffer access goes through one pointer. Each data-port read or write uses the pointer and steps it by one, modulo eight. Software can clear the pointer through a control bit and read its value back. After a command, software clears the pointer, reads past the bytes it sent, and then collects the reply. When a command sends no data bytes, the first received byte is treated as a turnaround byte and dropped, so software asks for one extra byte. The serial side uses mode 0, MSB first, with one fixed clock divider.

Top module: `spiFlashCmd`

## Requirements
- R1: After reset, chip select is high, SCK is low, the busy flags read 0, the pointer reads 0, and the opcode and count registers read 0.
- R2: The opcode register is at address 0x0. The count register is at 0x1, with the transmit byte count in bits 3:0 and the receive byte count in bits 7:4. Both read back what was written.
- R3: Writing 1 to bit 0 at address 0x2 starts a command. While the command runs, bit 0 of 0x2 and bit 7 of 0x3 read 1. Both read 0 once chip select has returned high.
- R4: MOSI carries the opcode first, then buffer entries 0, 1, … for the transmit count, then 0x00 bytes during the receive phase. Each byte goes MSB first. MOSI changes only on SCK falling edges, and MISO is sampled on rising edges. There are exactly 8×(1+tx+rx) rising edges.
- R5: The first SCK rising edge comes one SCK period (2×HALF_DIV clocks) after chip select falls. Chip select rises one SCK period after the last falling edge. SCK stays low while chip select is high.
- R6: Address 0xC is the buffer port. A write stores the byte at the pointer, and a read returns the byte at the pointer. Either access steps the pointer by one, modulo 8. Bits 2:0 of address 0xD read the pointer.
- R7: Writing 1 to bit 4 of address 0x2 sets the pointer to 0. That bit reads back as 0.
- R8: With a nonzero transmit count tx, receive byte k is stored at entry (tx+k) mod 8. The transmitted entries stay unchanged, and the byte received during the opcode is discarded.
- R9: With a zero transmit count, the first received byte is discarded, and received byte k (k ≥ 1) is stored at entry (k−1) mod 8.
- R10: A transmit count above 8 is treated as 8 for both the serial stream and placement. Receive placement wraps modulo 8 within the buffer.
- R11: While a command runs, all bus writes are ignored, and data-port reads do not move the pointer. The engine itself never changes the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 4 | Register address |
| regWrEn | input | 1 | Write strobe, one cycle per write |
| regWrData | input | 8 | Write data |
| regRdEn | input | 1 | Read strobe (advances pointer on the data port) |
| regRdData | output | 8 | Read data, combinational from regAddr |
| spiSck | output | 1 | Serial clock, idle low |
| spiCsN | output | 1 | Chip select, active low |
| spiMosi | output | 1 | Serial data out |
| spiMiso | input | 1 | Serial data in |

## Verification
The assertions assume a bus that issues at most one access per cycle, never a read and a write together. They also assume MISO changes only while SCK is low. The bench keeps to this: its bus tasks run one strobe per cycle, and its flash model updates MISO only when chip select falls or SCK falls. The only bus writes issued during a command come from one deliberate test, and that test checks that those writes are ignored.

// File: rtl/spiCmdPkg.sv
package spiCmdPkg;
  localparam int FIFO_DEPTH = 8;
  localparam int PTR_W      = $clog2(FIFO_DEPTH);
  localparam int CNT_W      = 4;
  localparam int ADDR_W     = 4;
  // highest byte index: opcode + clamped tx + max rx
  localparam int BYTE_W     = $clog2(1 + FIFO_DEPTH + (1 << CNT_W));

  localparam logic [ADDR_W-1:0] A_OPCODE = 4'h0;
  localparam logic [ADDR_W-1:0] A_COUNT  = 4'h1;
  localparam logic [ADDR_W-1:0] A_CTRL   = 4'h2;
  localparam logic [ADDR_W-1:0] A_STAT   = 4'h3;
  localparam logic [ADDR_W-1:0] A_DATA   = 4'hC;
  localparam logic [ADDR_W-1:0] A_PTR    = 4'hD;

  typedef struct packed {
    logic             loadOp;
    logic             loadFifo;
    logic             loadZero;
    logic             shiftOut;
    logic             sampleIn;
    logic             storeRx;
    logic [PTR_W-1:0] txIdx;
    logic [PTR_W-1:0] rxIdx;
  } engStb_t;
endpackage

// File: rtl/spiCmdCtrl.sv
module spiCmdCtrl
  import spiCmdPkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [CNT_W-1:0] txCnt,
  input  logic [CNT_W-1:0] rxCnt,
  output engStb_t          stb,
  output logic             spiSck,
  output logic             spiCsN,
  output logic             busy
);
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_XFER, S_HOLD} state_t;

  state_t            state;
  logic [DIV_W-1:0]  divCnt;
  logic [2:0]        bitCnt;
  logic [BYTE_W-1:0] byteIdx;
  logic [BYTE_W-1:0] nextIdx;
  logic [BYTE_W-1:0] lastIdx;
  logic [BYTE_W-1:0] txEffW;
  logic [CNT_W-1:0]  txEff;
  logic              halfSel;
  logic              tick;
  logic              byteEnd;

  assign busy    = (state != S_IDLE);
  assign tick    = (divCnt == DIV_W'(HALF_DIV - 1));
  assign txEff   = (txCnt > CNT_W'(FIFO_DEPTH)) ? CNT_W'(FIFO_DEPTH) : txCnt;
  assign txEffW  = BYTE_W'(txEff);
  assign lastIdx = txEffW + BYTE_W'(rxCnt);
  assign byteEnd = (state == S_XFER) && tick && spiSck && (bitCnt == 3'd7);
  assign nextIdx = byteIdx + BYTE_W'(1);

  always_comb begin
    stb          = '0;
    stb.loadOp   = (state == S_IDLE) && startReq;
    stb.sampleIn = (state == S_XFER) && tick && !spiSck;
    stb.shiftOut = (state == S_XFER) && tick && spiSck && (bitCnt != 3'd7);
    stb.txIdx    = byteIdx[PTR_W-1:0];
    if (byteEnd && (byteIdx != lastIdx)) begin
      if (nextIdx <= txEffW) stb.loadFifo = 1'b1;
      else                   stb.loadZero = 1'b1;
    end
    stb.storeRx = byteEnd && (byteIdx > txEffW) &&
                  ((txEff != '0) || (byteIdx >= BYTE_W'(2)));
    stb.rxIdx   = (txEff != '0) ? PTR_W'(byteIdx - BYTE_W'(1))
                                : PTR_W'(byteIdx - BYTE_W'(2));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      divCnt  <= '0;
      bitCnt  <= '0;
      byteIdx <= '0;
      halfSel <= 1'b0;
      spiSck  <= 1'b0;
      spiCsN  <= 1'b1;
    end else begin
      if (state != S_IDLE) divCnt <= tick ? '0 : divCnt + DIV_W'(1);
      case (state)
        S_IDLE: if (startReq) begin
          state   <= S_SETUP;
          spiCsN  <= 1'b0;
          divCnt  <= '0;
          bitCnt  <= '0;
          byteIdx <= '0;
          halfSel <= 1'b0;
        end
        S_SETUP: if (tick) state <= S_XFER;
        S_XFER: if (tick) begin
          if (!spiSck) spiSck <= 1'b1;
          else begin
            spiSck <= 1'b0;
            bitCnt <= bitCnt + 3'd1;
            if (bitCnt == 3'd7) begin
              if (byteIdx == lastIdx) begin
                state   <= S_HOLD;
                halfSel <= 1'b0;
              end else begin
                byteIdx <= nextIdx;
              end
            end
          end
        end
        S_HOLD: if (tick) begin
          halfSel <= ~halfSel;
          if (halfSel) begin
            spiCsN <= 1'b1;
            state  <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R5: clock is parked low whenever the device is deselected
  p_sck_parked_r5: assert property (@(posedge clk) disable iff (!rstN)
    spiCsN |-> !spiSck);
  // R5: a rising SCK edge only follows a cycle with chip select already low
  p_rise_selected_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(spiSck) |-> !$past(spiCsN));
  // R3: idle engine keeps the device deselected
  p_idle_deselect_r3: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> spiCsN);
  // R3: an accepted start selects the device on the next cycle
  p_start_selects_r3: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && !busy) |=> (busy && !spiCsN));
endmodule

// File: rtl/spiCmdData.sv
module spiCmdData
  import spiCmdPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [7:0]        regWrData,
  input  logic              regRdEn,
  output logic [7:0]        regRdData,
  input  logic              busy,
  input  engStb_t           stb,
  input  logic              spiMiso,
  output logic              spiMosi,
  output logic              startReq,
  output logic [CNT_W-1:0]  txCnt,
  output logic [CNT_W-1:0]  rxCnt
);
  logic [7:0]       opcodeReg;
  logic [7:0]       countReg;
  logic [7:0]       fifoMem [FIFO_DEPTH];
  logic [PTR_W-1:0] ptr;
  logic [7:0]       txShift;
  logic [7:0]       rxShift;
  logic             wrOk;
  logic             ptrClr;
  logic             portAcc;

  assign wrOk     = regWrEn && !busy;
  assign ptrClr   = wrOk && (regAddr == A_CTRL) && regWrData[4];
  assign startReq = wrOk && (regAddr == A_CTRL) && regWrData[0];
  assign portAcc  = (regAddr == A_DATA) && !busy && (regWrEn || regRdEn);
  assign txCnt    = countReg[CNT_W-1:0];
  assign rxCnt    = countReg[7:CNT_W];
  assign spiMosi  = busy && txShift[7];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opcodeReg <= '0;
      countReg  <= '0;
      ptr       <= '0;
    end else begin
      if (wrOk && regAddr == A_OPCODE) opcodeReg <= regWrData;
      if (wrOk && regAddr == A_COUNT)  countReg  <= regWrData;
      if (ptrClr)       ptr <= '0;
      else if (portAcc) ptr <= ptr + PTR_W'(1);
    end
  end

  for (genvar i = 0; i < FIFO_DEPTH; i++) begin : g_entry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        fifoMem[i] <= '0;
      else if (wrOk && regAddr == A_DATA && ptr == PTR_W'(i))
        fifoMem[i] <= regWrData;
      else if (stb.storeRx && stb.rxIdx == PTR_W'(i))
        fifoMem[i] <= rxShift;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
    end else begin
      if (stb.loadOp)        txShift <= opcodeReg;
      else if (stb.loadFifo) txShift <= fifoMem[stb.txIdx];
      else if (stb.loadZero) txShift <= '0;
      else if (stb.shiftOut) txShift <= {txShift[6:0], 1'b0};
      if (stb.sampleIn)      rxShift <= {rxShift[6:0], spiMiso};
    end
  end

  always_comb begin
    case (regAddr)
      A_OPCODE: regRdData = opcodeReg;
      A_COUNT:  regRdData = countReg;
      A_CTRL:   regRdData = {7'd0, busy};
      A_STAT:   regRdData = {busy, 7'd0};
      A_DATA:   regRdData = fifoMem[ptr];
      A_PTR:    regRdData = 8'(ptr);
      default:  regRdData = '0;
    endcase
  end

  // R6: every accepted port access steps the pointer by one
  p_ptr_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    portAcc |=> (ptr == $past(ptr) + PTR_W'(1)));
  // R7: a pointer clear lands at zero
  p_ptr_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    ptrClr |=> (ptr == '0));
  // R11: registers and pointer are frozen while a command runs
  p_busy_freeze_r11: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> ($stable(opcodeReg) && $stable(countReg) && $stable(ptr)));
endmodule

// File: rtl/spiFlashCmd.sv
module spiFlashCmd
  import spiCmdPkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] regAddr,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  input  logic       regRdEn,
  output logic [7:0] regRdData,
  output logic       spiSck,
  output logic       spiCsN,
  output logic       spiMosi,
  input  logic       spiMiso
);
  engStb_t          stb;
  logic             busy;
  logic             startReq;
  logic [CNT_W-1:0] txCnt;
  logic [CNT_W-1:0] rxCnt;

  spiCmdCtrl #(.HALF_DIV(HALF_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .txCnt(txCnt), .rxCnt(rxCnt),
    .stb(stb), .spiSck(spiSck), .spiCsN(spiCsN), .busy(busy)
  );

  spiCmdData u_data (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdEn(regRdEn), .regRdData(regRdData),
    .busy(busy), .stb(stb), .spiMiso(spiMiso), .spiMosi(spiMosi),
    .startReq(startReq), .txCnt(txCnt), .rxCnt(rxCnt)
  );
endmodule

// File: tb/sim_spiFlashCmd.sv
module sim_spiFlashCmd;
  localparam int HD = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] regAddr = '0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic       regRdEn = 1'b0;
  logic [7:0] regRdData;
  logic       spiSck, spiCsN, spiMosi;
  logic       spiMiso = 1'b0;

  int  nChk = 0, nFail = 0;
  bit  finished = 0;

  always #2 clk = ~clk;

  spiFlashCmd #(.HALF_DIV(HD)) u0 (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdEn(regRdEn), .regRdData(regRdData),
    .spiSck(spiSck), .spiCsN(spiCsN), .spiMosi(spiMosi), .spiMiso(spiMiso)
  );

  // flash model: replies resp[], records MOSI bytes in cap[]
  logic [7:0] resp [32];
  logic [7:0] cap  [32];
  int         sRise = 0;

  always @(negedge spiCsN) begin
    sRise = 0;
    for (int i = 0; i < 32; i++) cap[i] = '0;
    spiMiso = resp[0][7];
  end
  always @(posedge spiSck) if (!spiCsN) begin
    cap[(sRise / 8) % 32] = {cap[(sRise / 8) % 32][6:0], spiMosi};
    sRise++;
  end
  always @(negedge spiSck) if (!spiCsN)
    spiMiso = resp[(sRise / 8) % 32][7 - (sRise % 8)];

  // edge timing recorder, sampled away from the active edge
  int cyc = 0, tCsFall = 0, tFirstRise = 0, tLastFall = 0, tCsRise = 0;
  bit firstSeen = 0, prevCs = 1, prevSck = 0;
  always @(negedge clk) begin
    cyc++;
    if (prevCs && !spiCsN) begin tCsFall = cyc; firstSeen = 0; end
    if (!prevSck && spiSck && !firstSeen) begin tFirstRise = cyc; firstSeen = 1; end
    if (prevSck && !spiSck) tLastFall = cyc;
    if (!prevCs && spiCsN) tCsRise = cyc;
    prevCs = spiCsN; prevSck = spiSck;
  end

  task automatic chk(bit ok, string req, int act, int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic busWr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic busRd(logic [3:0] a, output logic [7:0] d);
    @(negedge clk); regAddr = a; regRdEn = 1'b1; #1 d = regRdData;
    @(negedge clk); regRdEn = 1'b0;
  endtask

  task automatic peek(logic [3:0] a, output logic [7:0] d);
    @(negedge clk); regAddr = a; #1 d = regRdData;
  endtask

  function automatic int effTx(logic [7:0] cnt);
    return (cnt[3:0] > 8) ? 8 : int'(cnt[3:0]);
  endfunction

  // run one command and check stream, timing and buffer against the model
  task automatic runCmd(logic [7:0] op, logic [7:0] cnt, bit meddle);
    logic [7:0] pre [8];
    logic [7:0] expF [8];
    logic [7:0] v;
    int tx, rx, lastB, guard;
    tx = effTx(cnt); rx = int'(cnt[7:4]); lastB = tx + rx;
    for (int i = 0; i < 32; i++) resp[i] = 8'($urandom);
    busWr(4'h2, 8'h10);
    for (int i = 0; i < 8; i++) begin pre[i] = 8'($urandom); busWr(4'hC, pre[i]); end
    busWr(4'h0, op);
    busWr(4'h1, cnt);
    for (int i = 0; i < 8; i++) expF[i] = pre[i];
    for (int n = 1; n <= lastB; n++) if (n > tx) begin
      if (tx > 0)       expF[(n - 1) % 8] = resp[n];
      else if (n >= 2)  expF[(n - 2) % 8] = resp[n];
    end
    busWr(4'h2, 8'h01);
    if (meddle) begin
      peek(4'h2, v); chk(v == 8'h01, "R3 ctrl busy", v, 1);
      peek(4'h3, v); chk(v == 8'h80, "R3 status busy", v, 8'h80);
      busWr(4'h0, ~op);
      busWr(4'h1, ~cnt);
      busWr(4'hC, 8'hA5);
      busWr(4'h2, 8'h10);
      busRd(4'hC, v);
    end
    guard = 0;
    do begin peek(4'h3, v); guard++; end while (v[7] && guard < 5000);
    peek(4'h2, v); chk(v == 8'h00, "R3 ctrl done", v, 0);
    chk(sRise == 8 * (1 + lastB), "R4 sck count", sRise, 8 * (1 + lastB));
    chk(cap[0] == op, "R4 opcode byte", cap[0], op);
    for (int n = 1; n <= lastB; n++) begin
      logic [7:0] e;
      e = (n <= tx) ? pre[n - 1] : 8'h00;
      chk(cap[n] == e, (n <= tx) ? "R4/R10 tx byte" : "R4 rx filler", cap[n], e);
    end
    chk(tFirstRise - tCsFall == 2 * HD, "R5 cs setup", tFirstRise - tCsFall, 2 * HD);
    chk(tCsRise - tLastFall == 2 * HD, "R5 cs hold", tCsRise - tLastFall, 2 * HD);
    peek(4'h0, v); chk(v == op, "R11 opcode kept", v, op);
    peek(4'h1, v); chk(v == cnt, "R11 count kept", v, cnt);
    peek(4'hD, v); chk(v == 8'h00, "R11 pointer kept", v, 0);
    for (int i = 0; i < 8; i++) begin
      busRd(4'hC, v);
      chk(v == expF[i], (tx == 0) ? "R9 buffer" : "R8/R10 buffer", v, expF[i]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChk++; nFail++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("[TB] %0d tests run, %0d failed", nChk, nFail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'h5A17));
    for (int i = 0; i < 32; i++) resp[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chk(spiCsN == 1'b1, "R1 csN", spiCsN, 1);
    chk(spiSck == 1'b0, "R1 sck", spiSck, 0);
    peek(4'h3, v); chk(v == 8'h00, "R1 status", v, 0);
    peek(4'h2, v); chk(v == 8'h00, "R1 ctrl", v, 0);
    peek(4'hD, v); chk(v == 8'h00, "R1 pointer", v, 0);
    peek(4'h0, v); chk(v == 8'h00, "R1 opcode", v, 0);
    peek(4'h1, v); chk(v == 8'h00, "R1 count", v, 0);
    // R2 register readback
    busWr(4'h0, 8'h9F); peek(4'h0, v); chk(v == 8'h9F, "R2 opcode", v, 8'h9F);
    busWr(4'h1, 8'h53); peek(4'h1, v); chk(v == 8'h53, "R2 count", v, 8'h53);
    // R6 pointer stepping and wrap, R7 clear
    busWr(4'h2, 8'h10);
    for (int i = 0; i < 3; i++) busWr(4'hC, 8'(8'h20 + i));
    peek(4'hD, v); chk(v == 8'h03, "R6 pointer after writes", v, 3);
    busWr(4'h2, 8'h10);
    peek(4'h2, v); chk(v == 8'h00, "R7 clear bit reads 0", v, 0);
    peek(4'hD, v); chk(v == 8'h00, "R7 pointer cleared", v, 0);
    busRd(4'hC, v); chk(v == 8'h20, "R6 read entry0", v, 8'h20);
    busRd(4'hC, v); chk(v == 8'h21, "R6 read entry1", v, 8'h21);
    for (int i = 0; i < 7; i++) busRd(4'hC, v);
    peek(4'hD, v); chk(v == 8'h01, "R6 pointer wrap", v, 1);
    // directed corners
    runCmd(8'h05, 8'h10, 1'b0);   // R9 only a turnaround byte
    runCmd(8'h9F, 8'h50, 1'b0);   // R9 four stored bytes
    runCmd(8'h02, 8'h08, 1'b0);   // R4 full transmit, no receive
    runCmd(8'h03, 8'hA3, 1'b1);   // R8 wrap in receive, R11 ignored writes
    runCmd(8'h0B, 8'h2C, 1'b0);   // R10 transmit count clamped
    runCmd(8'hAB, 8'hF0, 1'b0);   // R9/R10 long receive wrap
    // constrained random commands
    for (int k = 0; k < 12; k++) begin
      logic [3:0] t;
      t = (($urandom % 5) == 0) ? 4'(9 + $urandom % 7) : 4'($urandom % 9);
      runCmd(8'($urandom), {4'($urandom), t}, 1'(k % 3 == 0));
    end
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end
endmodule